// File: doc/BRIEF.md
# Half-Cycle AC RMS Voltage Estimator

This block turns a stream of unsigned 8-bit converter codes into an AC RMS figure with the DC bias taken out. The waveform reaches the converter on top of a fixed offset, so every code holds both the offset and the AC part. The block keeps the most recent 64 accepted samples in a circular store. Alongside the store it keeps a running sum of the samples and a running sum of their squares, and it updates both on every accepted sample.

When a voltage zero-crossing strobe arrives and the store is full, the block takes a snapshot of the two sums. From the snapshot it forms the scaled variance `D = 64*sum(x^2) - (sum x)^2`. If rounding ever made this negative it would be clamped to zero, but with exact integer sums that cannot happen. A one-bit-per-cycle restoring integer square root then yields `floor(sqrt(D))`, and the top eight bits of that root are the RMS result. Each result covers one full AC cycle and appears once per half cycle.

The control sequence has five named states. IDLE goes to DIFF on a zero-crossing strobe when the store is full. DIFF latches `D` and always moves to START. START pulses the root engine and always moves to ROOT. ROOT waits for the engine's done pulse and then moves to EMIT. EMIT raises the valid strobe for one cycle and returns to IDLE. The root engine has two states of its own: WAIT, and STEP, which it leaves after its fourteenth iteration.

Top module: `hc_rms_est`

## Requirements
- R1: While and just after reset, `rms_valid`, `busy` and `rms_out` are 0, and the sample store is empty.
- R2: A code on `smp_code` is taken into the store only in a cycle where `smp_stb` is 1. Codes presented with `smp_stb` at 0 have no effect on any result.
- R3: Until 64 samples have been accepted since reset, a zero-crossing strobe is ignored: `busy` stays 0 and no result is produced.
- R4: A result equals `floor(sqrt(mean(x^2) - mean(x)^2))` over the 64 most recently accepted samples, given as an unsigned 8-bit value on `rms_out`.
- R5: A sample accepted in the same cycle as the zero-crossing strobe is part of the window used for that result.
- R6: A zero-crossing strobe seen in IDLE with a full store sets `busy` from the next cycle onward. `rms_valid` is then a single-cycle pulse within 24 clock cycles of the strobe, and `busy` falls after it.
- R7: A zero-crossing strobe that arrives while `busy` is 1 is dropped, and no second result follows.
- R8: Samples accepted while `busy` is 1 do not change the result in flight. They enter the window for later results.
- R9: `rms_out` changes only in the cycle in which `rms_valid` is 1, and holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Qualifies `smp_code` for one cycle |
| smp_code | input | 8 | Unsigned converter code, AC signal plus DC offset |
| zc_stb | input | 1 | Single-cycle voltage zero-crossing event |
| rms_out | output | 8 | Most recent AC RMS result in converter codes |
| rms_valid | output | 1 | One-cycle pulse marking a new `rms_out` |
| busy | output | 1 | High while a result is being computed |

## Verification
A stale or misplaced entry in the circular store, or a running sum that fails to retire the oldest sample, does not stay hidden. It surfaces as a wrong `rms_out` at the first zero crossing after the corrupted sample. Known waveforms (square, alternating and three-level patterns) give exact closed-form RMS values, so any such error shows within one window of 64 samples. A control sequence that misses a state shows at once as an extra or missing `rms_valid` pulse, or as `busy` with the wrong length, within 24 cycles of the strobe. A fill counter that is wrong shows as a result that appears before 64 samples have been accepted.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIFF,
        ST_START,
        ST_ROOT,
        ST_EMIT
    } est_state_e;

    typedef enum logic {
        SQ_WAIT,
        SQ_STEP
    } sq_state_e;

endpackage

// File: rtl/hcr_window.sv
module hcr_window #(
    parameter int SAMPLE_W = 8,
    parameter int WIN      = 64,
    localparam int LOG2_WIN = $clog2(WIN),
    localparam int SUM_W    = SAMPLE_W + LOG2_WIN,
    localparam int SQ_W     = 2 * SAMPLE_W + LOG2_WIN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_code,
    output logic                win_full,
    output logic [SUM_W-1:0]    sum_o,
    output logic [SQ_W-1:0]     sumsq_o
);

    localparam int FILL_W = LOG2_WIN + 1;
    localparam int MAXV   = (1 << SAMPLE_W) - 1;

    logic [SAMPLE_W-1:0]   mem_q [WIN];
    logic [LOG2_WIN-1:0]   wr_ptr_q;
    logic [FILL_W-1:0]     fill_q;
    logic [SUM_W-1:0]      sum_q;
    logic [SQ_W-1:0]       sumsq_q;

    logic [SAMPLE_W-1:0]   old_code;
    logic [2*SAMPLE_W-1:0] new_sq;
    logic [2*SAMPLE_W-1:0] old_sq;

    always_comb begin
        old_code = mem_q[wr_ptr_q];
        new_sq   = smp_code * smp_code;
        old_sq   = old_code * old_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN; i++) begin
                mem_q[i] <= '0;
            end
            wr_ptr_q <= '0;
            fill_q   <= '0;
            sum_q    <= '0;
            sumsq_q  <= '0;
        end else if (smp_stb) begin
            mem_q[wr_ptr_q] <= smp_code;
            wr_ptr_q        <= wr_ptr_q + 1'b1;
            sum_q           <= sum_q + SUM_W'(smp_code) - SUM_W'(old_code);
            sumsq_q         <= sumsq_q + SQ_W'(new_sq) - SQ_W'(old_sq);
            if (fill_q != FILL_W'(WIN)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    assign win_full = (fill_q == FILL_W'(WIN));
    assign sum_o    = sum_q;
    assign sumsq_o  = sumsq_q;

    AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(WIN)); // R3
    AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q <= SUM_W'(WIN * MAXV)); // R4
    AST_SUM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(sum_q) && $stable(sumsq_q)); // R2

endmodule

// File: rtl/hcr_isqrt.sv
module hcr_isqrt #(
    parameter int ROOT_W = 14,
    localparam int RAD_W = 2 * ROOT_W,
    localparam int CNT_W = $clog2(ROOT_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RAD_W-1:0]  radicand,
    output logic              done,
    output logic [ROOT_W-1:0] root
);

    import hcr_pkg::*;

    sq_state_e          sq_state_q, sq_state_d;
    logic [RAD_W-1:0]   rad_q;
    logic [RAD_W-1:0]   op_q;
    logic [RAD_W-1:0]   res_q;
    logic [RAD_W-1:0]   one_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               done_q;
    logic [RAD_W-1:0]   trial;
    logic               last_step;

    always_comb begin
        trial     = res_q + one_q;
        last_step = (cnt_q == CNT_W'(ROOT_W - 1));
    end

    always_comb begin
        sq_state_d = sq_state_q;
        unique case (sq_state_q)
            SQ_WAIT: if (start)     sq_state_d = SQ_STEP;
            SQ_STEP: if (last_step) sq_state_d = SQ_WAIT;
            default:                sq_state_d = SQ_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_state_q <= SQ_WAIT;
        end else begin
            sq_state_q <= sq_state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad_q  <= '0;
            op_q   <= '0;
            res_q  <= '0;
            one_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (sq_state_q == SQ_WAIT && start) begin
                rad_q <= radicand;
                op_q  <= radicand;
                res_q <= '0;
                one_q <= RAD_W'(1) << (RAD_W - 2);
                cnt_q <= '0;
            end else if (sq_state_q == SQ_STEP) begin
                if (op_q >= trial) begin
                    op_q  <= op_q - trial;
                    res_q <= (res_q >> 1) + one_q;
                end else begin
                    res_q <= res_q >> 1;
                end
                one_q <= one_q >> 2;
                cnt_q <= cnt_q + 1'b1;
                if (last_step) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign root = res_q[ROOT_W-1:0];

    logic [RAD_W:0] root_sq_lo;
    logic [RAD_W:0] root_sq_hi;
    always_comb begin
        root_sq_lo = (RAD_W+1)'(root) * (RAD_W+1)'(root);
        root_sq_hi = ((RAD_W+1)'(root) + 1'b1) * ((RAD_W+1)'(root) + 1'b1);
    end

    AST_ROOT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (root_sq_lo <= {1'b0, rad_q}) && (root_sq_hi > {1'b0, rad_q})); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6

endmodule

// File: rtl/hc_rms_est.sv
module hc_rms_est #(
    parameter int SAMPLE_W = 8,
    parameter int WIN      = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_code,
    input  logic                zc_stb,
    output logic [SAMPLE_W-1:0] rms_out,
    output logic                rms_valid,
    output logic                busy
);

    import hcr_pkg::*;

    localparam int LOG2_WIN = $clog2(WIN);
    localparam int SUM_W    = SAMPLE_W + LOG2_WIN;
    localparam int SQ_W     = 2 * SAMPLE_W + LOG2_WIN;
    localparam int ROOT_W   = SAMPLE_W + LOG2_WIN;
    localparam int RAD_W    = 2 * ROOT_W;

    logic              win_full;
    logic [SUM_W-1:0]  sum_w;
    logic [SQ_W-1:0]   sumsq_w;

    est_state_e        state_q, state_d;
    logic [RAD_W-1:0]  diff_q;
    logic [SAMPLE_W-1:0] rms_q;
    logic              sq_start;
    logic              sq_done;
    logic [ROOT_W-1:0] sq_root;

    logic [RAD_W-1:0]  scaled_sq;
    logic [RAD_W-1:0]  mean_term;
    logic [RAD_W-1:0]  diff_d;

    hcr_window #(
        .SAMPLE_W (SAMPLE_W),
        .WIN      (WIN)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .smp_code (smp_code),
        .win_full (win_full),
        .sum_o    (sum_w),
        .sumsq_o  (sumsq_w)
    );

    hcr_isqrt #(
        .ROOT_W (ROOT_W)
    ) u_isqrt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sq_start),
        .radicand (diff_q),
        .done     (sq_done),
        .root     (sq_root)
    );

    // Scaled variance: WIN*sum(x^2) - (sum x)^2, clamped at zero.
    always_comb begin
        scaled_sq = {sumsq_w, {LOG2_WIN{1'b0}}};
        mean_term = RAD_W'(sum_w) * RAD_W'(sum_w);
        diff_d    = (scaled_sq >= mean_term) ? (scaled_sq - mean_term) : '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (zc_stb && win_full) state_d = ST_DIFF;
            ST_DIFF:  state_d = ST_START;
            ST_START: state_d = ST_ROOT;
            ST_ROOT:  if (sq_done) state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
            rms_q  <= '0;
        end else begin
            if (state_q == ST_DIFF) begin
                diff_q <= diff_d;
            end
            if (state_q == ST_ROOT && sq_done) begin
                rms_q <= sq_root[ROOT_W-1 -: SAMPLE_W];
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        rms_valid = (state_q == ST_EMIT);
        sq_start  = (state_q == ST_START);
    end

    assign rms_out = rms_q;

    AST_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> win_full); // R3
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(zc_stb)); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rms_valid |=> !rms_valid && !busy); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rms_out) |-> rms_valid); // R9
    AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROOT) |-> $stable(diff_q)); // R8

endmodule

// File: tb/tb_hc_rms_est.sv
module tb_hc_rms_est;

    localparam int NVEC = 8;
    // Columns: pattern kind, offset, amplitude, expected RMS.
    // Kinds: 0 constant, 1 half high / half low, 2 alternating per sample,
    // 3 quarter high, quarter low, half at offset.
    localparam int VEC [NVEC][4] = '{
        '{0, 200,   0,   0},
        '{1, 128,  50,  50},
        '{2, 100,  30,  30},
        '{1, 127, 127, 127},
        '{3, 128, 100,  70},
        '{3, 100,  64,  45},
        '{2,  60,   1,   1},
        '{0,   0,   0,   0}
    };

    logic       clk;
    logic       rst_n;
    logic       smp_stb;
    logic [7:0] smp_code;
    logic       zc_stb;
    logic [7:0] rms_out;
    logic       rms_valid;
    logic       busy;

    int checks;
    int errors;
    int hist [64];
    int hptr;
    int hcount;
    bit finished;

    hc_rms_est dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .smp_code  (smp_code),
        .zc_stb    (zc_stb),
        .rms_out   (rms_out),
        .rms_valid (rms_valid),
        .busy      (busy)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic int gen(input int kind, input int off, input int amp, input int i);
        case (kind)
            1: return (i < 32) ? off + amp : off - amp;
            2: return (i % 2 == 0) ? off + amp : off - amp;
            3: return (i < 16) ? off + amp : ((i < 32) ? off - amp : off);
            default: return off;
        endcase
    endfunction

    function automatic int model_rms();
        int s1 = 0;
        int s2 = 0;
        int d;
        int r = 0;
        for (int i = 0; i < 64; i++) begin
            s1 += hist[i];
            s2 += hist[i] * hist[i];
        end
        d = 64 * s2 - s1 * s1;
        while ((r + 1) * (r + 1) * 4096 <= d) r++;
        return r;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 64; i++) hist[i] = 0;
        hptr = 0;
        hcount = 0;
    endtask

    task automatic model_push(input int c);
        hist[hptr] = c;
        hptr = (hptr + 1) % 64;
        if (hcount < 64) hcount++;
    endtask

    // All tasks start and end at a falling edge.
    task automatic push(input int c, input bit with_zc);
        smp_stb  = 1'b1;
        smp_code = 8'(c);
        zc_stb   = with_zc;
        @(negedge clk);
        smp_stb = 1'b0;
        zc_stb  = 1'b0;
        model_push(c);
    endtask

    task automatic pulse_zc();
        zc_stb = 1'b1;
        @(negedge clk);
        zc_stb = 1'b0;
    endtask

    task automatic wait_valid(input int limit, output bit got, output int lat);
        got = 1'b0;
        lat = 0;
        for (int c = 1; c <= limit; c++) begin
            @(negedge clk);
            if (rms_valid) begin
                got = 1'b1;
                lat = c;
                break;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_stb = 1'b0;
        zc_stb = 1'b0;
        smp_code = 8'd0;
        repeat (3) @(negedge clk);
        check(rms_valid == 1'b0 && busy == 1'b0 && rms_out == 8'd0, "R1 reset outputs",
              {rms_valid, busy, rms_out}, 0);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        bit got;
        int lat;
        int exp;
        int pulses;
        int held;
        checks = 0;
        errors = 0;
        finished = 1'b0;
        rst_n = 1'b0;
        smp_stb = 1'b0;
        zc_stb = 1'b0;
        smp_code = 8'd0;
        @(negedge clk);
        do_reset();

        // R3: 63 samples are not enough; zero crossing is ignored.
        for (int i = 0; i < 63; i++) push(150, 1'b0);
        pulse_zc();
        check(busy == 1'b0, "R3 busy after early zc", busy, 0);
        wait_valid(40, got, lat);
        check(got == 1'b0, "R3 no result before full", got, 0);

        // R4/R6: table of waveforms.
        for (int v = 0; v < NVEC; v++) begin
            for (int i = 0; i < 64; i++) push(gen(VEC[v][0], VEC[v][1], VEC[v][2], i), 1'b0);
            pulse_zc();
            check(busy == 1'b1, "R6 busy after zc", busy, 1);
            wait_valid(40, got, lat);
            check(got && lat <= 24, "R6 valid latency", lat, 24);
            check(rms_out == 8'(VEC[v][3]), "R4 rms value", rms_out, VEC[v][3]);
            check(rms_out == 8'(model_rms()), "R4 rms model", rms_out, model_rms());
            @(negedge clk);
            check(rms_valid == 1'b0 && busy == 1'b0, "R6 single pulse", {rms_valid, busy}, 0);
        end

        // R9: output holds while samples keep flowing without a zero crossing.
        held = rms_out;
        for (int i = 0; i < 30; i++) push(255, 1'b0);
        check(rms_out == 8'(held), "R9 output held", rms_out, held);

        // R2: codes without strobe are ignored.
        for (int i = 0; i < 64; i++) push(90, 1'b0);
        smp_code = 8'd250;
        repeat (10) @(negedge clk);
        pulse_zc();
        wait_valid(40, got, lat);
        check(got && rms_out == 8'd0, "R2 unstrobed codes ignored", rms_out, 0);

        // R5: sample in the same cycle as zc is included.
        for (int i = 0; i < 63; i++) push(80, 1'b0);
        push(208, 1'b1);
        exp = model_rms();
        wait_valid(40, got, lat);
        check(got && rms_out == 8'(exp) && exp == 15, "R5 same-cycle sample", rms_out, exp);

        // R7 and R8: second zc while busy dropped; samples while busy ignored for this result.
        for (int i = 0; i < 64; i++) push(80, 1'b0);
        pulse_zc();
        push(250, 1'b0);
        push(250, 1'b0);
        check(busy == 1'b1, "R7 busy during run", busy, 1);
        pulse_zc();
        for (int i = 0; i < 8; i++) push(250, 1'b0);
        pulses = 0;
        exp = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (rms_valid) begin
                pulses++;
                exp = rms_out;
            end
        end
        check(pulses == 1, "R7 zc while busy dropped", pulses, 1);
        check(exp == 0, "R8 result uses snapshot", exp, 0);

        // R8: the samples taken while busy are in the next window.
        pulse_zc();
        wait_valid(40, got, lat);
        exp = model_rms();
        check(got && rms_out == 8'(exp), "R8 later window includes samples", rms_out, exp);

        // R1: reset mid-computation clears outputs and empties the store.
        for (int i = 0; i < 64; i++) push(gen(1, 128, 40, i), 1'b0);
        pulse_zc();
        repeat (4) @(negedge clk);
        do_reset();
        for (int i = 0; i < 63; i++) push(gen(1, 128, 40, i), 1'b0);
        pulse_zc();
        wait_valid(40, got, lat);
        check(got == 1'b0 && rms_out == 8'd0, "R1 store empty after reset", rms_out, 0);
        push(128, 1'b0);
        pulse_zc();
        wait_valid(40, got, lat);
        exp = model_rms();
        check(got && rms_out == 8'(exp), "R3 result once full", rms_out, exp);

        finish_run();
    end

endmodule